// File: doc/BRIEF.md
# Timed Frame Sync Generator

The block issues short frame-sync pulses to a serial transmitter at chosen 10 µs time slots. Each train of pulses is referenced to a line-locked 720 Hz timing event. When the event strobe arrives, the block first waits a programmable number of clock cycles. It then steps a slot counter through every slot index. Each slot lasts a fixed number of clock cycles. At the start of any slot whose index matches an enabled entry of a small slot table, the block drives a pulse a few cycles long. Each pulse starts the transmission of one data frame.

The delay moves the whole train relative to the event. The slot table sets the spacing between frames. The two are tuned independently, and a train can hold as many frames as the table has entries. Table and delay writes land in a staging copy, and that copy is taken over only when an event arrives. A train that is already running therefore never changes part way through. A new event always abandons the current train and starts again.

With the default 10 MHz clock, a slot is 100 cycles and a pulse is 10 cycles. The table holds 16 entries, and each entry has an enable bit and an 8-bit slot index.

Top module: `fsync_slot_gen`

## Requirements
- R1: After reset, `fsync_o` is low, every table entry is disabled and the delay is 0, so that an event arriving before any write produces no pulse.
- R2: If the delay taken over at an event is d, slot 0 begins d+1 clock edges after the edge that samples `evt_i` high, and `fsync_o` first becomes visible in the cycle that follows that edge.
- R3: Slot s begins SLOT_CYC·s edges after slot 0. For every enabled entry whose slot index equals s, `fsync_o` is high for exactly the first PULSE_CYC cycles of slot s.
- R4: An entry whose enable bit is 0 produces no pulse, whatever its slot index.
- R5: When several enabled entries name the same slot, one pulse of PULSE_CYC cycles is produced for that slot, and it is no longer than a single entry would give.
- R6: An event always restarts the sequence. In the cycle after it is sampled, `fsync_o` is low, even if a pulse was in progress, and timing restarts as in R2.
- R7: Writes to the table (`tbl_we`, entry `tbl_addr`) or to the delay (`dly_we`) made while a train is running do not alter that train. They apply from the next event onward. A write in the same cycle as an event applies from the event after it.
- R8: After the last slot index (2^IDX_W − 1) has passed, `fsync_o` stays low until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | One-cycle strobe of the 720 Hz timing event |
| tbl_we | input | 1 | Write strobe for a slot-table entry |
| tbl_addr | input | $clog2(N_ENT) | Entry to write |
| tbl_en | input | 1 | Enable bit of the written entry |
| tbl_slot | input | IDX_W | Slot index of the written entry |
| dly_we | input | 1 | Write strobe for the event delay |
| dly_val | input | DLY_W | Event delay in clock cycles |
| fsync_o | output | 1 | Frame-sync pulse |

## Verification
The bench builds the block with SLOT_CYC=8, PULSE_CYC=3, N_ENT=4, IDX_W=4 and DLY_W=4. A full train then lasts 128 cycles, so every delay value and every slot index, including the last, can be walked in a few thousand cycles. Every cycle of every train is compared against an arithmetic model of slot, offset and pulse position. The runs include duplicate entries, disabled entries, a restart in the middle of a train, and writes staged during a train.

// File: rtl/fsync_slot_gen.sv
module fsync_slot_gen #(
  parameter int SLOT_CYC  = 100,
  parameter int PULSE_CYC = 10,
  parameter int N_ENT     = 16,
  parameter int IDX_W     = 8,
  parameter int DLY_W     = 16,
  localparam int AW = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             tbl_we,
  input  logic [AW-1:0]    tbl_addr,
  input  logic             tbl_en,
  input  logic [IDX_W-1:0] tbl_slot,
  input  logic             dly_we,
  input  logic [DLY_W-1:0] dly_val,
  output logic             fsync_o
);

  logic             stg_en   [N_ENT];
  logic [IDX_W-1:0] stg_slot [N_ENT];
  logic             act_en   [N_ENT];
  logic [IDX_W-1:0] act_slot [N_ENT];
  logic [DLY_W-1:0] stg_dly, dly_cnt;
  logic             waiting, running;
  logic [IDX_W-1:0] slot_cnt;
  logic [CW-1:0]    cyc_cnt;
  logic [N_ENT-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        stg_en[i]   <= 1'b0;
        stg_slot[i] <= '0;
        act_en[i]   <= 1'b0;
        act_slot[i] <= '0;
      end
      stg_dly <= '0;
    end else begin
      if (evt_i) begin
        for (int i = 0; i < N_ENT; i++) begin
          act_en[i]   <= stg_en[i];
          act_slot[i] <= stg_slot[i];
        end
      end
      if (tbl_we && (int'(tbl_addr) < N_ENT)) begin
        stg_en[tbl_addr]   <= tbl_en;
        stg_slot[tbl_addr] <= tbl_slot;
      end
      if (dly_we) stg_dly <= dly_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      running  <= 1'b0;
      dly_cnt  <= '0;
      slot_cnt <= '0;
      cyc_cnt  <= '0;
    end else if (evt_i) begin
      waiting <= 1'b1;
      running <= 1'b0;
      dly_cnt <= stg_dly;
    end else if (waiting) begin
      if (dly_cnt == '0) begin
        waiting  <= 1'b0;
        running  <= 1'b1;
        slot_cnt <= '0;
        cyc_cnt  <= '0;
      end else begin
        dly_cnt <= dly_cnt - 1'b1;
      end
    end else if (running) begin
      if (cyc_cnt == CW'(SLOT_CYC - 1)) begin
        cyc_cnt <= '0;
        if (slot_cnt == '1) running <= 1'b0;
        else                slot_cnt <= slot_cnt + 1'b1;
      end else begin
        cyc_cnt <= cyc_cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit[g] = act_en[g] && (act_slot[g] == slot_cnt);
  end

  assign fsync_o = running && (|hit) && (int'(cyc_cnt) < PULSE_CYC);

endmodule

module fsync_slot_gen_chk #(
  parameter int SLOT_CYC  = 100,
  parameter int PULSE_CYC = 10,
  parameter int IDX_W     = 8,
  parameter int DLY_W     = 16
) (
  input logic clk,
  input logic rst_n,
  input logic evt_i,
  input logic fsync_o
);
  localparam longint LIM = (longint'(1) << DLY_W) + (longint'(1) << IDX_W) * SLOT_CYC;

  longint since_evt;
  int     hi_cnt;
  logic   seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_evt <= 0;
      hi_cnt    <= 0;
      seen      <= 1'b0;
    end else begin
      if (evt_i) begin
        since_evt <= 0;
        seen      <= 1'b1;
      end else if (since_evt <= LIM) begin
        since_evt <= since_evt + 1;
      end
      hi_cnt <= fsync_o ? ((hi_cnt < PULSE_CYC + 1) ? hi_cnt + 1 : hi_cnt) : 0;
    end
  end

  a_r1_silent_before_event: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> seen);
  a_r2_not_before_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> (since_evt != 0));
  a_r3_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> (hi_cnt < PULSE_CYC));
  a_r6_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> !fsync_o);
  a_r8_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> (since_evt < LIM));
endmodule

bind fsync_slot_gen fsync_slot_gen_chk #(
  .SLOT_CYC(SLOT_CYC), .PULSE_CYC(PULSE_CYC), .IDX_W(IDX_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .fsync_o(fsync_o)
);

// File: tb/fsync_slot_gen_tb.sv
`timescale 1ns/1ps
module fsync_slot_gen_tb;
  localparam int SLOT  = 8;
  localparam int PULSE = 3;
  localparam int NE    = 4;
  localparam int IW    = 4;
  localparam int DW    = 4;
  localparam int NSLOT = 1 << IW;
  localparam int WIN   = (1 << DW) + 1 + NSLOT * SLOT + 20;

  logic clk = 1'b0, rst_n = 1'b0, evt_i = 1'b0;
  logic tbl_we = 1'b0, tbl_en = 1'b0, dly_we = 1'b0;
  logic [1:0] tbl_addr = '0;
  logic [IW-1:0] tbl_slot = '0;
  logic [DW-1:0] dly_val = '0;
  logic fsync_o;

  int errors = 0, checks = 0;
  int k = 0;
  bit armed = 0, restart = 0;
  string req = "R1";
  bit pend_en[NE];  int pend_slot[NE];  int pend_d = 0;
  bit act_en[NE];   int act_slot[NE];   int act_d = 0;

  fsync_slot_gen #(.SLOT_CYC(SLOT), .PULSE_CYC(PULSE), .N_ENT(NE), .IDX_W(IW), .DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_en(tbl_en), .tbl_slot(tbl_slot), .dly_we(dly_we), .dly_val(dly_val), .fsync_o(fsync_o));

  always #2.5 clk = ~clk;

  function automatic bit expect_at(int kk);
    int j, s;
    if (!armed || kk < act_d + 1) return 1'b0;
    j = kk - act_d - 1;
    s = j / SLOT;
    if (s >= NSLOT || (j % SLOT) >= PULSE) return 1'b0;
    for (int i = 0; i < NE; i++) if (act_en[i] && act_slot[i] == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic tick();
    bit e;
    @(negedge clk);
    evt_i = 1'b0; tbl_we = 1'b0; dly_we = 1'b0;
    if (restart) begin k = 0; armed = 1; restart = 0; end
    e = expect_at(k);
    checks++;
    if (fsync_o !== e) begin
      errors++;
      $display("FAIL %s k=%0d d=%0d actual=%0b expected=%0b", req, k, act_d, fsync_o, e);
    end
    k++;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fire();
    evt_i = 1'b1;
    for (int i = 0; i < NE; i++) begin act_en[i] = pend_en[i]; act_slot[i] = pend_slot[i]; end
    act_d = pend_d;
    restart = 1;
  endtask

  task automatic put_ent(int a, bit en, int s);
    tbl_we = 1'b1; tbl_addr = 2'(a); tbl_en = en; tbl_slot = IW'(s);
    pend_en[a] = en; pend_slot[a] = s;
  endtask

  task automatic put_dly(int d);
    dly_we = 1'b1; dly_val = DW'(d); pend_d = d;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin pend_en[i] = 0; pend_slot[i] = 0; act_en[i] = 0; act_slot[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, then an event with the reset table gives nothing
    req = "R1"; ticks(20);
    fire(); ticks(WIN);

    // R2 R3 R4 R8: delay sweep with first, middle and last slot, one disabled entry
    put_ent(0, 1, 0); tick();
    put_ent(1, 1, 3); tick();
    put_ent(2, 1, 15); tick();
    put_ent(3, 0, 5); tick();
    for (int d = 0; d < (1 << DW); d++) begin
      req = (d % 2) ? "R2" : "R8";
      put_dly(d); tick();
      fire(); ticks(WIN);
    end

    // R3 R4: table pattern sweep
    for (int p = 0; p < 16; p++) begin
      req = (p % 2) ? "R3" : "R4";
      for (int i = 0; i < NE; i++) begin put_ent(i, p[i], (p * 3 + i * 5) % NSLOT); tick(); end
      put_dly(p); tick();
      fire(); ticks(WIN);
    end

    // R5: all entries on one slot give a single pulse
    req = "R5";
    for (int i = 0; i < NE; i++) begin put_ent(i, 1, 7); tick(); end
    put_ent(2, 1, 8); tick();
    put_dly(1); tick();
    fire(); ticks(WIN);

    // R6 R7: staged writes during a train, restart mid-pulse, write with event
    req = "R7";
    put_ent(0, 1, 2); tick();
    put_ent(1, 0, 0); tick();
    put_ent(2, 0, 0); tick();
    put_ent(3, 0, 0); tick();
    put_dly(4); tick();
    fire(); ticks(10);
    put_ent(0, 1, 1); put_dly(2); ticks(22);
    req = "R6";
    fire(); put_ent(1, 1, 6); ticks(WIN);
    req = "R7";
    fire(); ticks(WIN);
    req = "R6";
    put_dly(0); tick();
    fire(); ticks(11);
    fire(); ticks(WIN);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule